// File: doc/BRIEF.md
# Receive Frame Match Engine

This block sits on the receive path of an Ethernet controller. It decides, for every incoming frame, whether the frame is kept or dropped. The decision comes from a programmable table of match entries. Each entry looks at one 32-bit word of the frame at a chosen word offset. It compares the bits selected by a mask against a stored value and names an action, accept or reject, together with a DMA channel number.

When a key does not start on a 4-byte boundary, software splits it across two consecutive entries. The first entry holds the upper bytes of the first word and is flagged as chained. The entry after it becomes a continuation that holds the low bytes of the next word. The pair matches only when both halves match.

The highest table index is a fixed catch-all entry. It accepts every frame on channel 0, so a frame that meets no other entry is still given a verdict. Frame words arrive as a stream with start and end markers. The verdict is issued as a one-cycle pulse as soon as every programmed offset has been seen, or at end of frame if that comes first. Table writes come in through a simple indexed write port and take effect only between frames.

Top module: `rx_frame_matcher`

## Requirements
- R1: An entry hits when the frame word at its offset satisfies `((word ^ matchData) & matchMask) == 0`. Offset 0 is the word that carries the start marker, and offsets count 32-bit words.
- R2: The deciding entry's accept flag gives an accept verdict and its reject flag gives a drop verdict. When both flags are set, reject wins. `verdictChan` carries the deciding entry's channel. An entry with neither flag that is not a continuation is disabled and never decides.
- R3: Entries are scanned in ascending index order, and the lowest-index entry that fully matches decides the verdict.
- R4: Index `ENTRIES-1` is a fixed catch-all: offset 0, zero mask, accept, last, channel 0. Writes to that index have no effect.
- R5: Setting the chain flag on entry i makes entry i+1 a continuation. Entry i fully matches only if both entries hit. A continuation never decides on its own, even when it hits.
- R6: An entry whose offset is at or beyond the number of words the frame has delivered does not hit.
- R7: `verdictValid` pulses high for exactly one cycle, two clock edges after the decisive word is sampled. The decisive word is the end-of-frame word, or the word whose index equals the largest offset among active entries, whichever comes first. Active entries are those with a flag set, plus continuations.
- R8: The scan stops after the first entry whose last flag is set. If no entry up to and including it matched, the verdict is drop with channel 0.
- R9: Words that arrive after the decisive word, up to end of frame, are ignored. Valid words outside a frame, and start markers inside a frame, are ignored as well.
- R10: A table write is applied only when no frame is in progress. A frame is in progress from its start word through both its end word and its verdict pulse. A write in the same cycle as an accepted start word is dropped.
- R11: After reset, `verdictValid` is low and every entry except the catch-all is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frmValid | input | 1 | Frame word valid |
| frmSof | input | 1 | Word is the first of a frame |
| frmEof | input | 1 | Word is the last of a frame |
| frmWord | input | 32 | Frame word |
| tblWe | input | 1 | Table write strobe |
| tblIdx | input | IDX_W | Entry index to write |
| tblData | input | 32 | Match value |
| tblMask | input | 32 | Match-enable mask |
| tblOffset | input | OFF_W | Word offset in frame |
| tblAccept | input | 1 | Accept action flag |
| tblReject | input | 1 | Reject action flag |
| tblLast | input | 1 | Stop scanning after this entry |
| tblChain | input | 1 | Next entry is this entry's continuation |
| tblChan | input | CHAN_W | DMA channel number |
| verdictValid | output | 1 | One-cycle verdict strobe |
| verdictAccept | output | 1 | 1 = accept, 0 = drop |
| verdictChan | output | CHAN_W | DMA channel of deciding entry |

## Verification
The hardest situation to reach from the ports is a verdict issued mid-frame while the frame keeps streaming. The same holds for a write that lands in the one-cycle resolve window between the end word and the verdict. The stimulus creates the first by placing an entry at a middle offset and sending a longer frame. It creates the second by holding the write strobe across a whole frame, including idle gaps and the cycle after the end word. A chained key is driven with only its head half present and then only its tail half present, to show that neither half alone decides. The bench model replays every cycle from the requirements alone and compares the verdict outputs on each clock.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

  // Strobes passed from the frame control to the match datapath.
  typedef struct packed {
    logic capture;   // a frame word is consumed this cycle
    logic first;     // that word is offset 0 (clears previous hits)
    logic resolve;   // hits are complete; produce the verdict
    logic write;     // apply the pending table write
  } rxp_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PARSE   = 2'd1,
    ST_RESOLVE = 2'd2,
    ST_SKIP    = 2'd3
  } rxp_state_t;

endpackage

// File: rtl/rxp_ctrl.sv
module rxp_ctrl
  import rxp_pkg::*;
#(
  parameter int OFF_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frmValid,
  input  logic             frmSof,
  input  logic             frmEof,
  input  logic             tblWe,
  input  logic [OFF_W-1:0] maxOff,
  output rxp_strobe_t      strb,
  output logic [OFF_W-1:0] wordIdx
);

  rxp_state_t       state;
  logic [OFF_W-1:0] wordCnt;
  logic             eofSeen;
  logic             startWord;
  logic             decisive;

  always_comb begin
    startWord    = (state == ST_IDLE) && frmValid && frmSof;
    strb.first   = startWord;
    strb.capture = startWord || ((state == ST_PARSE) && frmValid);
    strb.resolve = (state == ST_RESOLVE);
    strb.write   = tblWe && (state == ST_IDLE) && !(frmValid && frmSof);
    wordIdx      = startWord ? '0 : wordCnt;
    decisive     = strb.capture && (frmEof || (wordIdx == maxOff));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordCnt <= '0;
      eofSeen <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE, ST_PARSE: begin
          if (strb.capture) begin
            wordCnt <= wordIdx + 1'b1;
            eofSeen <= frmEof;
            state   <= decisive ? ST_RESOLVE : ST_PARSE;
          end
        end
        ST_RESOLVE: begin
          state <= (eofSeen || (frmValid && frmEof)) ? ST_IDLE : ST_SKIP;
        end
        ST_SKIP: begin
          if (frmValid && frmEof) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: a resolve cycle always follows a consumed frame word
  a_r7_resolve_after_word: assert property (@(posedge clk) disable iff (!rstN)
    strb.resolve |-> $past(strb.capture));

  // R10: the table never changes in a cycle that consumes frame data
  a_r10_no_write_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    strb.write |-> !strb.capture);

endmodule

// File: rtl/rxp_table.sv
module rxp_table
  import rxp_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int OFF_W   = 4,
  parameter int CHAN_W  = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxp_strobe_t       strb,
  input  logic [OFF_W-1:0]  wordIdx,
  input  logic [31:0]       frmWord,
  input  logic [IDX_W-1:0]  tblIdx,
  input  logic [31:0]       tblData,
  input  logic [31:0]       tblMask,
  input  logic [OFF_W-1:0]  tblOffset,
  input  logic              tblAccept,
  input  logic              tblReject,
  input  logic              tblLast,
  input  logic              tblChain,
  input  logic [CHAN_W-1:0] tblChan,
  output logic [OFF_W-1:0]  maxOff,
  output logic              verdictValid,
  output logic              verdictAccept,
  output logic [CHAN_W-1:0] verdictChan
);

  typedef struct packed {
    logic [31:0]       data;
    logic [31:0]       mask;
    logic [OFF_W-1:0]  off;
    logic              acc;
    logic              rej;
    logic              last;
    logic              chain;
    logic [CHAN_W-1:0] chan;
  } entry_t;

  localparam entry_t CATCH_ALL = '{data: '0, mask: '0, off: '0, acc: 1'b1,
                                   rej: 1'b0, last: 1'b1, chain: 1'b0, chan: '0};

  entry_t              stored [ENTRIES-1];
  entry_t              tbl    [ENTRIES];
  logic [ENTRIES-1:0]  wordHit;
  logic [ENTRIES-1:0]  hit;
  logic [ENTRIES-1:0]  nextHit;
  logic [ENTRIES-1:0]  cont;
  logic [ENTRIES-1:0]  active;
  logic                selFound;
  logic                selAcc;
  logic [CHAN_W-1:0]   selChan;

  // Programmable entries; the top index is the fixed catch-all (R4).
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES-1; i++) stored[i] <= '0;
    end else if (strb.write && (tblIdx != IDX_W'(ENTRIES-1))) begin
      stored[tblIdx] <= '{data: tblData, mask: tblMask, off: tblOffset,
                          acc: tblAccept, rej: tblReject, last: tblLast,
                          chain: tblChain, chan: tblChan};
    end
  end

  always_comb begin
    for (int i = 0; i < ENTRIES-1; i++) tbl[i] = stored[i];
    tbl[ENTRIES-1] = CATCH_ALL;
  end

  // Per-entry compare of the current word and continuation marking.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    assign wordHit[g] = (tbl[g].off == wordIdx) &&
                        (((frmWord ^ tbl[g].data) & tbl[g].mask) == 32'd0);
    if (g == 0) begin : g_head
      assign cont[g] = 1'b0;
    end else begin : g_tail
      assign cont[g] = tbl[g-1].chain;
    end
    assign active[g] = tbl[g].acc || tbl[g].rej || cont[g];
  end

  assign nextHit = {1'b0, hit[ENTRIES-1:1]};

  // Largest word offset any active entry still needs to see.
  always_comb begin
    maxOff = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (active[i] && (tbl[i].off > maxOff)) maxOff = tbl[i].off;
  end

  // Hit accumulation across the words of one frame.
  always_ff @(posedge clk) begin
    if (!rstN) hit <= '0;
    else if (strb.capture) hit <= (strb.first ? '0 : hit) | wordHit;
  end

  // Ascending-priority resolve, stopping after a last-marked entry.
  always_comb begin
    logic stop;
    stop     = 1'b0;
    selFound = 1'b0;
    selAcc   = 1'b0;
    selChan  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!stop && !selFound && !cont[i] && (tbl[i].acc || tbl[i].rej) &&
          hit[i] && (!tbl[i].chain || nextHit[i])) begin
        selFound = 1'b1;
        selAcc   = tbl[i].acc && !tbl[i].rej;
        selChan  = tbl[i].chan;
      end
      if (tbl[i].last) stop = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      verdictValid  <= 1'b0;
      verdictAccept <= 1'b0;
      verdictChan   <= '0;
    end else begin
      verdictValid <= strb.resolve;
      if (strb.resolve) begin
        verdictAccept <= selAcc;
        verdictChan   <= selChan;
      end
    end
  end

  // R4: the catch-all sits at offset 0, so every resolved frame has hit it
  a_r4_catchall_hit: assert property (@(posedge clk) disable iff (!rstN)
    strb.resolve |-> hit[ENTRIES-1]);

  // R7: the verdict strobe lasts exactly one cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    verdictValid |=> !verdictValid);

endmodule

// File: rtl/rx_frame_matcher.sv
module rx_frame_matcher
  import rxp_pkg::*;
#(
  parameter int ENTRIES       = 64,
  parameter int MAX_OFF_BYTES = 64,
  parameter int CHAN_W        = 4,
  localparam int IDX_W        = $clog2(ENTRIES),
  localparam int OFF_WORDS    = MAX_OFF_BYTES / 4,
  localparam int OFF_W        = $clog2(OFF_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frmValid,
  input  logic              frmSof,
  input  logic              frmEof,
  input  logic [31:0]       frmWord,
  input  logic              tblWe,
  input  logic [IDX_W-1:0]  tblIdx,
  input  logic [31:0]       tblData,
  input  logic [31:0]       tblMask,
  input  logic [OFF_W-1:0]  tblOffset,
  input  logic              tblAccept,
  input  logic              tblReject,
  input  logic              tblLast,
  input  logic              tblChain,
  input  logic [CHAN_W-1:0] tblChan,
  output logic              verdictValid,
  output logic              verdictAccept,
  output logic [CHAN_W-1:0] verdictChan
);

  rxp_strobe_t      strb;
  logic [OFF_W-1:0] wordIdx;
  logic [OFF_W-1:0] maxOff;

  rxp_ctrl #(.OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .frmValid(frmValid), .frmSof(frmSof),
    .frmEof(frmEof), .tblWe(tblWe), .maxOff(maxOff), .strb(strb),
    .wordIdx(wordIdx)
  );

  rxp_table #(.ENTRIES(ENTRIES), .OFF_W(OFF_W), .CHAN_W(CHAN_W)) u_table (
    .clk(clk), .rstN(rstN), .strb(strb), .wordIdx(wordIdx), .frmWord(frmWord),
    .tblIdx(tblIdx), .tblData(tblData), .tblMask(tblMask),
    .tblOffset(tblOffset), .tblAccept(tblAccept), .tblReject(tblReject),
    .tblLast(tblLast), .tblChain(tblChain), .tblChan(tblChan),
    .maxOff(maxOff), .verdictValid(verdictValid),
    .verdictAccept(verdictAccept), .verdictChan(verdictChan)
  );

endmodule

// File: tb/rx_frame_matcher_test.sv
`timescale 1ns/1ps
module rx_frame_matcher_test;

  localparam int N   = 64;
  localparam int OFW = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frmValid = 0, frmSof = 0, frmEof = 0;
  logic [31:0] frmWord = '0;
  logic        tblWe = 0;
  logic [5:0]  tblIdx = '0;
  logic [31:0] tblData = '0, tblMask = '0;
  logic [3:0]  tblOffset = '0;
  logic        tblAccept = 0, tblReject = 0, tblLast = 0, tblChain = 0;
  logic [3:0]  tblChan = '0;
  logic        verdictValid, verdictAccept;
  logic [3:0]  verdictChan;

  always #2 clk = ~clk;

  rx_frame_matcher uut (.*);

  int checks = 0, fails = 0;
  string curReq = "R11";
  bit done = 0;

  // ---------------- behavioural reference ----------------
  bit [31:0] mData [N], mMask [N];
  int        mOff [N], mChan [N];
  bit        mAcc [N], mRej [N], mLast [N], mChain [N];
  bit [31:0] fw [OFW];
  int        fLen = 0;
  bit        parsing = 0, waitEof = 0, pend = 0, pendAcc = 0;
  int        pendChan = 0;
  bit        expVld = 0, expAcc = 0;
  int        expChan = 0;

  function automatic bit isCont(int i);
    return (i > 0) && mChain[i-1];
  endfunction

  function automatic int modelMaxOff();
    int m = 0;
    for (int i = 0; i < N; i++)
      if ((mAcc[i] || mRej[i] || isCont(i)) && mOff[i] > m) m = mOff[i];
    return m;
  endfunction

  function automatic bit hits(int i);
    if (i >= N || mOff[i] >= fLen) return 0;
    return ((fw[mOff[i]] ^ mData[i]) & mMask[i]) == 0;
  endfunction

  task automatic modelVerdict(output bit acc, output int ch);
    acc = 0; ch = 0;
    for (int i = 0; i < N; i++) begin
      if (!isCont(i) && (mAcc[i] || mRej[i]) && hits(i) && (!mChain[i] || hits(i+1))) begin
        acc = mAcc[i] && !mRej[i];
        ch  = mChan[i];
        return;
      end
      if (mLast[i]) return;
    end
  endtask

  task automatic modelStep();
    bit freeTbl, nPend, nAcc;
    int nCh;
    freeTbl = !parsing && !waitEof && !pend;
    nPend = 0; nAcc = 0; nCh = 0;
    expVld = pend;
    if (pend) begin expAcc = pendAcc; expChan = pendChan; end
    if (freeTbl && tblWe && !(frmValid && frmSof) && tblIdx != N-1) begin
      mData[tblIdx] = tblData; mMask[tblIdx] = tblMask; mOff[tblIdx] = tblOffset;
      mAcc[tblIdx] = tblAccept; mRej[tblIdx] = tblReject; mLast[tblIdx] = tblLast;
      mChain[tblIdx] = tblChain; mChan[tblIdx] = tblChan;
    end
    if (freeTbl && frmValid && frmSof) begin parsing = 1; fLen = 0; end
    if (parsing && frmValid) begin
      fw[fLen] = frmWord;
      fLen++;
      if (frmEof || (fLen - 1) == modelMaxOff()) begin
        parsing = 0;
        waitEof = !frmEof;
        modelVerdict(nAcc, nCh);
        nPend = 1;
      end
    end else if (waitEof && frmValid && frmEof) begin
      waitEof = 0;
    end
    pend = nPend; pendAcc = nAcc; pendChan = nCh;
  endtask

  task automatic compare();
    checks++;
    if (verdictValid !== expVld ||
        (expVld && (verdictAccept !== expAcc || verdictChan !== 4'(expChan)))) begin
      fails++;
      $display("FAIL %s @%0t: valid/accept/chan = %0b/%0b/%0d, expected %0b/%0b/%0d",
               curReq, $time, verdictValid, verdictAccept, verdictChan,
               expVld, expAcc, expChan);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    #1;
    compare();
  endtask

  // ---------------- stimulus helpers ----------------
  bit [31:0] fb [OFW];

  task automatic clearBuf();
    for (int i = 0; i < OFW; i++) fb[i] = 32'h0;
  endtask

  task automatic idle(int n);
    frmValid = 0; frmSof = 0; frmEof = 0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic sendFrame(int len, bit gap, bit weDuring);
    for (int w = 0; w < len; w++) begin
      frmValid = 1; frmSof = (w == 0); frmEof = (w == len - 1);
      frmWord = (w < OFW) ? fb[w] : 32'hA5A5_0000 + w;
      tblWe = weDuring;
      tick();
      if (gap && w != len - 1) begin frmValid = 0; tick(); end
    end
    frmValid = 0; frmSof = 0; frmEof = 0;
    tick();                 // resolve cycle; a held write is still blocked
    tblWe = 0;
    idle(3);
  endtask

  task automatic writeEntry(int idx, bit [31:0] d, bit [31:0] m, int off,
                            bit a, bit r, bit l, bit c, int ch);
    tblIdx = 6'(idx); tblData = d; tblMask = m; tblOffset = 4'(off);
    tblAccept = a; tblReject = r; tblLast = l; tblChain = c; tblChan = 4'(ch);
    tblWe = 1; tick(); tblWe = 0; tick();
  endtask

  task automatic setWriteFields(int idx, bit [31:0] d, bit [31:0] m, int off,
                                bit a, bit r, bit l, bit c, int ch);
    tblIdx = 6'(idx); tblData = d; tblMask = m; tblOffset = 4'(off);
    tblAccept = a; tblReject = r; tblLast = l; tblChain = c; tblChan = 4'(ch);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R7: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    for (int i = 0; i < N; i++) begin
      mData[i] = 0; mMask[i] = 0; mOff[i] = 0; mAcc[i] = 0; mRej[i] = 0;
      mLast[i] = 0; mChain[i] = 0; mChan[i] = 0;
    end
    mAcc[N-1] = 1; mLast[N-1] = 1;       // catch-all as required by R4
    repeat (4) @(posedge clk);
    #1 rstN = 1;
    curReq = "R11"; compare();           // reset state: no verdict
    idle(2);

    // R11 / R4: empty table, catch-all accepts on channel 0
    curReq = "R4"; clearBuf(); sendFrame(4, 0, 0);

    // R1: masked match at word offset 3
    curReq = "R1";
    writeEntry(0, 32'hABCD_0000, 32'hFFFF_0000, 3, 1, 0, 0, 0, 5);
    clearBuf(); fb[3] = 32'hABCD_1234; sendFrame(5, 0, 0);
    clearBuf(); fb[3] = 32'hABCE_0000; sendFrame(5, 1, 0);

    // R2: reject action, and reject winning over accept
    curReq = "R2";
    writeEntry(1, 32'h1111_1111, 32'hFFFF_FFFF, 1, 0, 1, 0, 0, 2);
    clearBuf(); fb[1] = 32'h1111_1111; sendFrame(4, 0, 0);
    writeEntry(2, 32'h0000_0077, 32'h0000_00FF, 0, 1, 1, 0, 0, 3);
    clearBuf(); fb[0] = 32'h5500_0077; sendFrame(4, 0, 0);

    // R3: entries 0 and 1 both hit; index 0 decides
    curReq = "R3";
    clearBuf(); fb[1] = 32'h1111_1111; fb[3] = 32'hABCD_9999; sendFrame(4, 0, 0);

    // R5: chained key across words 5 and 6
    curReq = "R5";
    writeEntry(4, 32'hBEEF_0000, 32'hFFFF_0000, 5, 1, 0, 0, 1, 6);
    writeEntry(5, 32'h0000_CAFE, 32'h0000_FFFF, 6, 0, 0, 0, 0, 0);
    clearBuf(); fb[5] = 32'hBEEF_0102; fb[6] = 32'h0304_CAFE; sendFrame(8, 0, 0);
    clearBuf(); fb[5] = 32'hBEEF_0102; sendFrame(8, 0, 0);
    clearBuf(); fb[6] = 32'h0304_CAFE; sendFrame(8, 1, 0);

    // R6: entry at offset 9, frames shorter and longer than that
    curReq = "R6";
    writeEntry(6, 32'h0, 32'h0, 9, 0, 1, 0, 0, 7);
    clearBuf(); sendFrame(8, 0, 0);
    clearBuf(); sendFrame(10, 0, 0);

    // R7 / R9: verdict at word 9 while frame continues to word 13
    curReq = "R7";
    clearBuf(); fb[12] = 32'hABCD_0000; sendFrame(14, 0, 0);
    curReq = "R9";
    clearBuf(); fb[3] = 32'hABCD_0000; sendFrame(14, 1, 0);
    // stray words outside any frame are ignored
    frmValid = 1; frmSof = 0; frmEof = 1; frmWord = 32'h1111_1111; tick(); tick();
    frmValid = 0; frmEof = 0; idle(2);
    clearBuf(); sendFrame(3, 0, 0);

    // R10: write held through a whole frame (gaps and resolve cycle) is dropped
    curReq = "R10";
    setWriteFields(7, 32'h0, 32'h0, 0, 1, 0, 0, 0, 9);
    clearBuf(); sendFrame(4, 1, 1);
    clearBuf(); sendFrame(4, 0, 0);        // still catch-all channel 0
    writeEntry(7, 32'h0, 32'h0, 0, 1, 0, 0, 0, 9);
    clearBuf(); sendFrame(4, 0, 0);        // now entry 7 on channel 9

    // R4: writes to the top index have no effect
    curReq = "R4";
    writeEntry(N-1, 32'h0, 32'h0, 0, 0, 1, 1, 0, 1);
    writeEntry(7, 32'h0, 32'h0, 0, 0, 0, 0, 0, 0);
    clearBuf(); sendFrame(4, 0, 0);

    // R8: last flag on entry 3 stops the scan
    curReq = "R8";
    writeEntry(3, 32'h1234_5678, 32'hFFFF_FFFF, 2, 1, 0, 1, 0, 11);
    clearBuf(); sendFrame(4, 0, 0);        // nothing before stop: drop ch 0
    clearBuf(); fb[2] = 32'h1234_5678; sendFrame(4, 0, 0);
    clearBuf(); fb[5] = 32'hBEEF_0000; fb[6] = 32'h0000_CAFE; sendFrame(8, 0, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule